// File: doc/BRIEF.md
# SIMD Wide-Immediate Instruction Decoder

This block takes one 32-bit instruction word and decides whether it belongs to the group of unpredicated vector integer operations that carry an 8-bit immediate. When the word belongs to the group, the block reports which of twelve operations it names, the element size, and the single register index. That register is both the source and the destination. It also reports the immediate, expanded to 64 bits in the form that the operation needs.

The immediate expansion depends on the operation. The add/subtract family takes an unsigned byte, which may be shifted left by eight. The signed compare forms and multiply sign-extend the byte. The unsigned compare forms zero-extend it. Any word outside the group, and any illegal combination inside it, gives valid low and all other outputs zero.

The decode is combinational. A parameter `REG_OUT` adds one register stage on the outputs (default 1). With this stage, results appear on the clock edge after the word is presented. An active-low asynchronous reset clears that stage.

Top module: `simd_imm_decoder`

## Requirements
- R1: A word is in the group only when bits 31:24 equal 8'h25. Any other value gives `valid_o` = 0.
- R2: For a valid word, `esize_o` equals bits 23:22 (0 byte, 1 half, 2 word, 3 double) and `reg_o` equals bits 4:0.
- R3: Add/subtract family: bits 21:19 = 3'b100 and bits 15:14 = 2'b11. Bits 18:16 select the operation and the op code: 000 ADD=1, 001 SUB=2, 011 RSUB=3, 100 SQADD=4, 101 UQADD=5, 110 SQSUB=6, 111 UQSUB=7. The value 010 is invalid.
- R4: In the add/subtract family, bits 12:5 are zero-extended to 64 bits. When bit 13 is set, the result is shifted left by 8.
- R5: An add/subtract word with element size 0 and bit 13 set is invalid.
- R6: Compare family: bits 21:19 = 3'b101 and bits 15:13 = 3'b110. Bits 18:16 select the operation and the op code: 000 SMAX=8, 001 UMAX=9, 010 SMIN=10, 011 UMIN=11. Values 1xx are invalid.
- R7: SMAX and SMIN sign-extend bits 12:5 to 64 bits. UMAX and UMIN zero-extend them. No shift applies, for any element size.
- R8: Multiply (op code 12) requires bits 21:19 = 3'b110, bits 18:16 = 3'b000 and bits 15:13 = 3'b110. Its immediate is bits 12:5, sign-extended. Any other word with bits 21:19 = 3'b110, and any other value of bits 21:19, is invalid.
- R9: When `valid_o` is 0, `op_o`, `esize_o`, `reg_o` and `imm_o` are all 0.
- R10: With `REG_OUT`=1, outputs change only at the rising clock edge, one cycle after the word is presented. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word to decode |
| valid_o | output | 1 | Word is a legal member of the group |
| op_o | output | 4 | Operation code (0 when invalid) |
| esize_o | output | 2 | Element size |
| reg_o | output | 5 | Source and destination register index |
| imm_o | output | 64 | Expanded immediate |

## Verification
On every cycle, the assertions check the following:
- any valid output traces back to a word with the group prefix;
- invalid outputs are all zero;
- unsigned compare immediates have no bits above bit 7;
- signed forms are a true sign extension of bit 7;
- add/subtract immediates keep their single non-zero byte in the lower or upper position, never in the upper position for bytes.

Only the bench scenarios can show that each opcode field maps to the right operation, that each unallocated code and fixed-bit mismatch is rejected, and that the one-cycle latency and the reset clearing behave at the ports.

// File: rtl/simd_imm_pkg.sv
package simd_imm_pkg;

    localparam int INSTR_W = 32;
    localparam int IMM_W   = 64;
    localparam int RAW_W   = 8;
    localparam int REG_W   = 5;
    localparam int ESZ_W   = 2;
    localparam int OP_W    = 4;
    localparam logic [7:0] GROUP_TAG = 8'h25;

    typedef enum logic [OP_W-1:0] {
        OP_NONE  = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_RSUB  = 4'd3,
        OP_SQADD = 4'd4,
        OP_UQADD = 4'd5,
        OP_SQSUB = 4'd6,
        OP_UQSUB = 4'd7,
        OP_SMAX  = 4'd8,
        OP_UMAX  = 4'd9,
        OP_SMIN  = 4'd10,
        OP_UMIN  = 4'd11,
        OP_MUL   = 4'd12
    } op_e;

    typedef struct packed {
        logic             valid;
        op_e              op;
        logic [ESZ_W-1:0] esz;
        logic [REG_W-1:0] rd;
        logic [IMM_W-1:0] imm;
    } dec_t;

endpackage

// File: rtl/simd_imm_class_dec.sv
module simd_imm_class_dec
    import simd_imm_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output op_e                op_o,
    output logic               sext_o,
    output logic               shift_o
);

    op_e  op_raw;
    logic sh_raw;

    // Family and opcode selection from the fixed bit fields
    always_comb begin
        op_raw = OP_NONE;
        sh_raw = 1'b0;
        if (instr_i[31:24] == GROUP_TAG) begin
            case (instr_i[21:19])
                3'b100: begin
                    if (instr_i[15:14] == 2'b11) begin
                        sh_raw = instr_i[13];
                        case (instr_i[18:16])
                            3'b000:  op_raw = OP_ADD;
                            3'b001:  op_raw = OP_SUB;
                            3'b011:  op_raw = OP_RSUB;
                            3'b100:  op_raw = OP_SQADD;
                            3'b101:  op_raw = OP_UQADD;
                            3'b110:  op_raw = OP_SQSUB;
                            3'b111:  op_raw = OP_UQSUB;
                            default: op_raw = OP_NONE;
                        endcase
                    end
                end
                3'b101: begin
                    if (instr_i[15:13] == 3'b110) begin
                        case (instr_i[18:16])
                            3'b000:  op_raw = OP_SMAX;
                            3'b001:  op_raw = OP_UMAX;
                            3'b010:  op_raw = OP_SMIN;
                            3'b011:  op_raw = OP_UMIN;
                            default: op_raw = OP_NONE;
                        endcase
                    end
                end
                3'b110: begin
                    if (instr_i[15:13] == 3'b110 && instr_i[18:16] == 3'b000)
                        op_raw = OP_MUL;
                end
                default: op_raw = OP_NONE;
            endcase
        end
    end

    // Byte elements cannot take the shifted immediate form
    always_comb begin
        op_o    = op_raw;
        shift_o = sh_raw;
        if (sh_raw && instr_i[23:22] == 2'b00) begin
            op_o    = OP_NONE;
            shift_o = 1'b0;
        end
        sext_o = (op_o == OP_SMAX) || (op_o == OP_SMIN) || (op_o == OP_MUL);
    end

endmodule

// File: rtl/simd_imm_expand.sv
module simd_imm_expand #(
    parameter int RAW_BITS = 8,
    parameter int OUT_BITS = 64
) (
    input  logic [RAW_BITS-1:0] raw_i,
    input  logic                sext_i,
    input  logic                shift_i,
    output logic [OUT_BITS-1:0] imm_o
);

    localparam int PAD_W = OUT_BITS - RAW_BITS;

    logic [OUT_BITS-1:0] base;

    always_comb begin
        base  = sext_i ? {{PAD_W{raw_i[RAW_BITS-1]}}, raw_i}
                       : {{PAD_W{1'b0}}, raw_i};
        imm_o = shift_i ? (base << RAW_BITS) : base;
    end

endmodule

// File: rtl/simd_imm_out_stage.sv
module simd_imm_out_stage
    import simd_imm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  dec_t d_i,
    output dec_t q_o
);

    generate
        if (REG_OUT) begin : g_reg
            dec_t q_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_pass
            assign q_o = d_i;
        end
    endgenerate

endmodule

// File: rtl/simd_imm_decoder.sv
module simd_imm_decoder
    import simd_imm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INSTR_W-1:0]  instr_i,
    output logic                valid_o,
    output logic [OP_W-1:0]     op_o,
    output logic [ESZ_W-1:0]    esize_o,
    output logic [REG_W-1:0]    reg_o,
    output logic [IMM_W-1:0]    imm_o
);

    op_e              cls_op;
    logic             cls_sext;
    logic             cls_shift;
    logic [IMM_W-1:0] wide_imm;
    dec_t             dec_d;
    dec_t             dec_q;

    simd_imm_class_dec u_class (
        .instr_i (instr_i),
        .op_o    (cls_op),
        .sext_o  (cls_sext),
        .shift_o (cls_shift)
    );

    simd_imm_expand #(
        .RAW_BITS (RAW_W),
        .OUT_BITS (IMM_W)
    ) u_expand (
        .raw_i   (instr_i[12:5]),
        .sext_i  (cls_sext),
        .shift_i (cls_shift),
        .imm_o   (wide_imm)
    );

    // Gather the result; every field is zero for an illegal word
    always_comb begin
        dec_d = '0;
        if (cls_op != OP_NONE) begin
            dec_d.valid = 1'b1;
            dec_d.op    = cls_op;
            dec_d.esz   = instr_i[23:22];
            dec_d.rd    = instr_i[4:0];
            dec_d.imm   = wide_imm;
        end
    end

    simd_imm_out_stage #(
        .REG_OUT (REG_OUT)
    ) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dec_d),
        .q_o   (dec_q)
    );

    assign valid_o = dec_q.valid;
    assign op_o    = dec_q.op;
    assign esize_o = dec_q.esz;
    assign reg_o   = dec_q.rd;
    assign imm_o   = dec_q.imm;

    // R9: an illegal result carries no stray fields
    a_r9_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (op_o == '0 && esize_o == '0 && reg_o == '0 && imm_o == '0));

    // R7: unsigned compare immediates are zero above bit 7
    a_r7_unsigned_zext: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (op_o == OP_UMAX || op_o == OP_UMIN)) |-> (imm_o[63:8] == '0));

    // R7, R8: signed forms replicate bit 7 through the upper bits
    a_r7_signed_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (op_o == OP_SMAX || op_o == OP_SMIN || op_o == OP_MUL))
        |-> (imm_o[63:7] == '0 || imm_o[63:7] == '1));

    // R4: add/subtract immediate is a single byte, low or shifted by 8
    a_r4_addsub_range: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && op_o >= OP_ADD && op_o <= OP_UQSUB)
        |-> (imm_o[63:16] == '0 && (imm_o[15:8] == '0 || imm_o[7:0] == '0)));

    // R5: no shifted immediate ever leaves with byte elements
    a_r5_no_byte_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && esize_o == 2'b00 && op_o >= OP_ADD && op_o <= OP_UQSUB)
        |-> (imm_o[63:8] == '0));

    generate
        if (REG_OUT) begin : g_chk_reg
            // R1, R10: a valid output came from a prefixed word one cycle earlier
            a_r1_prefix_past: assert property (@(posedge clk) disable iff (!rst_n)
                valid_o |-> ($past(instr_i[31:24]) == GROUP_TAG));
        end else begin : g_chk_comb
            // R1: a valid output needs the prefix on the current word
            a_r1_prefix_now: assert property (@(posedge clk) disable iff (!rst_n)
                valid_o |-> (instr_i[31:24] == GROUP_TAG));
        end
    endgenerate

endmodule

// File: tb/simd_imm_decoder_tb_top.sv
module simd_imm_decoder_tb_top;

    // Row: esz[92:91] fam[90:88] sel[87:85] mid[84:82] raw[81:74] rd[73:69]
    //      exp_valid[68] exp_op[67:64] exp_imm[63:0]
    localparam int NV = 20;
    localparam logic [92:0] VEC [NV] = '{
        {2'd1, 3'b100, 3'b000, 3'b110, 8'h7F, 5'd3,  1'b1, 4'd1,  64'h7F},               // R3 R4 add
        {2'd2, 3'b100, 3'b000, 3'b111, 8'h80, 5'd31, 1'b1, 4'd1,  64'h8000},             // R4 shifted
        {2'd0, 3'b100, 3'b000, 3'b111, 8'h80, 5'd4,  1'b0, 4'd0,  64'h0},                // R5 byte shift
        {2'd3, 3'b100, 3'b001, 3'b110, 8'hFF, 5'd7,  1'b1, 4'd2,  64'hFF},               // R3 sub
        {2'd1, 3'b100, 3'b011, 3'b111, 8'h01, 5'd9,  1'b1, 4'd3,  64'h100},              // R3 rsub
        {2'd1, 3'b100, 3'b010, 3'b110, 8'h11, 5'd9,  1'b0, 4'd0,  64'h0},                // R3 code 010
        {2'd0, 3'b100, 3'b100, 3'b110, 8'h12, 5'd1,  1'b1, 4'd4,  64'h12},               // R3 sqadd
        {2'd2, 3'b100, 3'b101, 3'b110, 8'h34, 5'd2,  1'b1, 4'd5,  64'h34},               // R3 uqadd
        {2'd3, 3'b100, 3'b110, 3'b111, 8'h56, 5'd5,  1'b1, 4'd6,  64'h5600},             // R3 sqsub
        {2'd1, 3'b100, 3'b111, 3'b110, 8'h9A, 5'd6,  1'b1, 4'd7,  64'h9A},               // R3 uqsub
        {2'd2, 3'b100, 3'b000, 3'b010, 8'h01, 5'd1,  1'b0, 4'd0,  64'h0},                // R3 bits15:14
        {2'd3, 3'b101, 3'b000, 3'b110, 8'h80, 5'd8,  1'b1, 4'd8,  64'hFFFFFFFFFFFFFF80}, // R6 R7 smax
        {2'd2, 3'b101, 3'b001, 3'b110, 8'h80, 5'd10, 1'b1, 4'd9,  64'h80},               // R7 umax
        {2'd0, 3'b101, 3'b010, 3'b110, 8'h7F, 5'd11, 1'b1, 4'd10, 64'h7F},               // R7 smin byte
        {2'd1, 3'b101, 3'b011, 3'b110, 8'hFE, 5'd12, 1'b1, 4'd11, 64'hFE},               // R7 umin
        {2'd1, 3'b101, 3'b100, 3'b110, 8'h05, 5'd13, 1'b0, 4'd0,  64'h0},                // R6 code 1xx
        {2'd1, 3'b101, 3'b000, 3'b111, 8'h05, 5'd13, 1'b0, 4'd0,  64'h0},                // R6 bits15:13
        {2'd2, 3'b110, 3'b000, 3'b110, 8'hF0, 5'd14, 1'b1, 4'd12, 64'hFFFFFFFFFFFFFFF0}, // R8 mul
        {2'd2, 3'b110, 3'b001, 3'b110, 8'hF0, 5'd14, 1'b0, 4'd0,  64'h0},                // R8 bad sel
        {2'd2, 3'b111, 3'b000, 3'b110, 8'h01, 5'd15, 1'b0, 4'd0,  64'h0}                 // R8 bad family
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic        valid_o;
    logic [3:0]  op_o;
    logic [1:0]  esize_o;
    logic [4:0]  reg_o;
    logic [63:0] imm_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    simd_imm_decoder dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .instr_i (instr),
        .valid_o (valid_o),
        .op_o    (op_o),
        .esize_o (esize_o),
        .reg_o   (reg_o),
        .imm_o   (imm_o)
    );

    function automatic string row_tag(int idx);
        case (idx)
            0, 3, 4, 5, 6, 7, 8, 9, 10: row_tag = "R3";
            1:                          row_tag = "R4";
            2:                          row_tag = "R5";
            11, 15, 16:                 row_tag = "R6";
            12, 13, 14:                 row_tag = "R7";
            default:                    row_tag = "R8";
        endcase
    endfunction

    task automatic check_all(string tag, logic ev, logic [3:0] eop, logic [1:0] ees,
                             logic [4:0] erd, logic [63:0] eimm);
        checks++;
        if (valid_o !== ev || op_o !== eop || esize_o !== ees || reg_o !== erd || imm_o !== eimm) begin
            fails++;
            $display("FAIL %s: got v=%0b op=%0d esz=%0d rd=%0d imm=%h, expected v=%0b op=%0d esz=%0d rd=%0d imm=%h",
                     tag, valid_o, op_o, esize_o, reg_o, imm_o, ev, eop, ees, erd, eimm);
        end
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R10: outputs held at zero in reset
        instr = {8'h25, 2'd1, 3'b100, 3'b000, 3'b110, 8'h11, 5'd2};
        repeat (3) @(negedge clk);
        check_all("R10 in reset", 1'b0, 4'd0, 2'd0, 5'd0, 64'h0);
        rst_n = 1'b1;

        // Table walk: R2 fields checked on every row
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            instr = {8'h25, VEC[i][92:69]};
            @(negedge clk);
            check_all(row_tag(i), VEC[i][68], VEC[i][67:64],
                      VEC[i][68] ? VEC[i][92:91] : 2'd0,
                      VEC[i][68] ? VEC[i][73:69] : 5'd0, VEC[i][63:0]);
        end

        // R1 R9: wrong prefix on an otherwise legal add
        @(negedge clk);
        instr = {8'h24, 2'd2, 3'b100, 3'b000, 3'b110, 8'h55, 5'd21};
        @(negedge clk);
        check_all("R1 R9 prefix", 1'b0, 4'd0, 2'd0, 5'd0, 64'h0);

        // R10 latency: new word not visible before the clock edge
        @(negedge clk);
        instr = {8'h25, 2'd3, 3'b101, 3'b001, 3'b110, 8'h42, 5'd17};
        #1;
        check_all("R10 before edge", 1'b0, 4'd0, 2'd0, 5'd0, 64'h0);
        @(negedge clk);
        check_all("R2 R10 after edge", 1'b1, 4'd9, 2'd3, 5'd17, 64'h42);

        // R10: reset mid-run clears held result at once
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_all("R10 async reset", 1'b0, 4'd0, 2'd0, 5'd0, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R2 R10 after release", 1'b1, 4'd9, 2'd3, 5'd17, 64'h42);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule